// File: doc/BRIEF.md
# Internal/External Oscillator Switch Controller

This block decides which of two oscillators clocks a small microcontroller and when the processor may run. After reset the core runs from the on-chip oscillator. Firmware can write an 8-bit clock configuration register to request the external resonator. The controller then stops the internal oscillator and halts the processor. It enables the external oscillator and waits for that oscillator to report that it is stable. It then counts a resume delay, whose length firmware chooses, before it lets the processor run again.

Once the part is running on the external clock, it stays there. Clearing the request bit changes nothing until the part is suspended and woken again. On wake, the request bit decides the clock source. With the bit clear, the internal oscillator is restarted and the processor waits only a short wake delay. With the bit set, the part goes back through the stable-then-resume sequence. The controller also decides what the resonator output pin carries, and it passes the remaining configuration fields through as plain outputs.

All delays are counted in time-base ticks: a cycle of the running clock is counted only when `tick` is high. The three delay lengths are parameters. The block has no data stream, so every pin is a plain control or status signal.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `clk_sel_ext`=0, `cpu_run`=1, `int_osc_en`=1, `ext_osc_en`=0, `xtal_drive`=1 (clock out) and `src_status`=0 (internal). The status codes are 0 internal, 1 external and 2 no clock.
- R2: A write with `io_addr`=0xF8 loads the register, and the value is visible on `cfg_rdata`. A write to any other address leaves the register unchanged. The register fields are: bit 7 long-resume select, bits 6:4 `wake_adj`, bit 3 `lvr_dis`, bit 2 `ptune_en`, bit 1 output disable, and bit 0 external request.
- R3: Writing bit 0 = 1 while running on the internal clock has a visible effect right after that clock edge. `cpu_run` and `int_osc_en` go to 0, `ext_osc_en` and `clk_sel_ext` go to 1, and `src_status` becomes 2.
- R4: While the external oscillator is not yet stable, the processor stays halted for as long as `osc_stable` stays low.
- R5: Call the edge where `osc_stable` is first seen high edge E0. `cpu_run` rises at edge E0+D, where D is RESUME_SHORT (default 128) when bit 7 is 0 and RESUME_LONG (default 4000) when bit 7 is 1. Bit 7 is taken at edge E0. During the delay `src_status` is 1.
- R6: Delays advance only on edges where `tick` is 1. With `tick` high on every other cycle, a delay takes about twice as many cycles.
- R7: While on the external clock, writing bit 0 = 0 changes neither `clk_sel_ext`, `cpu_run` nor the oscillator enables. Only a wake from suspend can return the part to the internal clock.
- R8: `suspend_req` while the processor runs halts it, turns both oscillators off and sets `src_status` to 2.
- R9: A `wake` pulse while suspended with bit 0 = 0 selects the internal clock and enables its oscillator. `cpu_run` rises WAKE_DELAY (default 8) ticks after the wake edge.
- R10: A `wake` pulse while suspended with bit 0 = 1 enables the external oscillator and keeps the processor halted. The part then follows R4 and R5.
- R11: `xtal_drive` is 1 (internal clock out) on the internal source with bit 1 = 0, and 2 (drive high) on the internal source with bit 1 = 1. It is 0 (released to the resonator) on the external source, whatever the value of bit 1.
- R12: `wake` has no effect unless the part is suspended. `suspend_req` has no effect unless the processor is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| cfg_rdata | output | 8 | Configuration register contents |
| osc_stable | input | 1 | External oscillator has settled |
| suspend_req | input | 1 | Request to enter suspend |
| wake | input | 1 | Wake event from suspend |
| tick | input | 1 | Time-base enable for delay counting |
| clk_sel_ext | output | 1 | 1 selects the external clock |
| int_osc_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| cpu_run | output | 1 | Processor may execute |
| xtal_drive | output | 2 | Resonator output pin: 0 released, 1 clock, 2 high |
| src_status | output | 2 | Active clock source: 0 internal, 1 external, 2 none |
| wake_adj | output | 3 | Wake-timer adjust field |
| lvr_dis | output | 1 | Low-voltage reset disable field |
| ptune_en | output | 1 | Precision tuning enable field |

## Verification
The hardest state to reach is a wake from suspend onto the external path with the long resume delay. Getting there needs a prior switch to the external clock, a suspend, and a rewrite of the register while the processor is halted. The stimulus writes 0x81 during suspend, then pulses `wake`. It holds `osc_stable` low for a while so that the halt can be observed, then releases it and counts edges until `cpu_run` rises. Tick gating is covered by toggling `tick` during a short resume delay.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [2:0] {
    ST_INT_RUN  = 3'd0,
    ST_EXT_WAIT = 3'd1,
    ST_EXT_DLY  = 3'd2,
    ST_EXT_RUN  = 3'd3,
    ST_SUSP     = 3'd4,
    ST_WAKE_INT = 3'd5
  } seq_state_e;

  typedef enum logic [1:0] {
    XD_RELEASE = 2'd0,
    XD_CLOCK   = 2'd1,
    XD_HIGH    = 2'd2
  } xtal_drive_e;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_NONE = 2'd2
  } src_e;

  localparam int unsigned BIT_EXT_REQ = 0;
  localparam int unsigned BIT_OUT_DIS = 1;
  localparam int unsigned BIT_PTUNE   = 2;
  localparam int unsigned BIT_LVR_DIS = 3;
  localparam int unsigned BIT_WADJ_LO = 4;
  localparam int unsigned BIT_LONG    = 7;
endpackage

// File: rtl/clksw_cfg_reg.sv
module clksw_cfg_reg #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [7:0]  REG_ADDR = 8'hF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] cfg_q,
  output logic          ext_set_pulse
);
  import clksw_pkg::*;

  logic hit;
  assign hit = io_wr && (io_addr == REG_ADDR[AW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (hit) cfg_q <= io_wdata;
  end

  // request pulse taken from the write itself, same edge as the load
  assign ext_set_pulse = hit && io_wdata[BIT_EXT_REQ];

  // R2
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != REG_ADDR[AW-1:0]) |=> $stable(cfg_q));
endmodule

// File: rtl/clksw_delay.sv
module clksw_delay #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_len,
  input  logic          tick,
  output logic          busy,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = busy && !load && tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      cnt_q <= load_len - 1'b1;
    end else if (busy && tick) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (!busy || cnt_q <= $past(cnt_q)));

  // R6
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !tick) |=> (busy && $stable(cnt_q)));
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq #(
  parameter int unsigned CW           = 12,
  parameter int unsigned RESUME_SHORT = 128,
  parameter int unsigned RESUME_LONG  = 4000,
  parameter int unsigned WAKE_DELAY   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_set_pulse,
  input  logic          ext_bit,
  input  logic          long_sel,
  input  logic          osc_stable,
  input  logic          suspend_req,
  input  logic          wake,
  input  logic          dly_expire,
  output logic          dly_load,
  output logic [CW-1:0] dly_len,
  output logic          src_ext,
  output logic          cpu_run,
  output logic          int_osc_en,
  output logic          ext_osc_en,
  output logic [1:0]    src_status
);
  import clksw_pkg::*;

  localparam logic [CW-1:0] LEN_SHORT = CW'(RESUME_SHORT);
  localparam logic [CW-1:0] LEN_LONG  = CW'(RESUME_LONG);
  localparam logic [CW-1:0] LEN_WAKE  = CW'(WAKE_DELAY);

  seq_state_e state_q, state_d;
  logic src_ext_q, src_ext_d;
  logic wake_int_go;

  assign wake_int_go = (state_q == ST_SUSP) && wake && !ext_bit;

  always_comb begin
    state_d   = state_q;
    src_ext_d = src_ext_q;
    unique case (state_q)
      ST_INT_RUN: begin
        if (ext_set_pulse) begin
          state_d   = ST_EXT_WAIT;
          src_ext_d = 1'b1;
        end else if (suspend_req) begin
          state_d = ST_SUSP;
        end
      end
      ST_EXT_WAIT: if (osc_stable) state_d = ST_EXT_DLY;
      ST_EXT_DLY:  if (dly_expire) state_d = ST_EXT_RUN;
      ST_EXT_RUN:  if (suspend_req) state_d = ST_SUSP;
      ST_SUSP: begin
        if (wake) begin
          if (ext_bit) begin
            state_d   = ST_EXT_WAIT;
            src_ext_d = 1'b1;
          end else begin
            state_d   = ST_WAKE_INT;
            src_ext_d = 1'b0;
          end
        end
      end
      ST_WAKE_INT: if (dly_expire) state_d = ST_INT_RUN;
      default: state_d = ST_INT_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_INT_RUN;
      src_ext_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      src_ext_q <= src_ext_d;
    end
  end

  assign dly_load = ((state_q == ST_EXT_WAIT) && osc_stable) || wake_int_go;
  assign dly_len  = wake_int_go ? LEN_WAKE : (long_sel ? LEN_LONG : LEN_SHORT);

  assign src_ext    = src_ext_q;
  assign cpu_run    = (state_q == ST_INT_RUN) || (state_q == ST_EXT_RUN);
  assign int_osc_en = (state_q == ST_INT_RUN) || (state_q == ST_WAKE_INT);
  assign ext_osc_en = (state_q == ST_EXT_WAIT) || (state_q == ST_EXT_DLY) ||
                      (state_q == ST_EXT_RUN);

  always_comb begin
    unique case (state_q)
      ST_INT_RUN, ST_WAKE_INT: src_status = SRC_INT;
      ST_EXT_DLY, ST_EXT_RUN:  src_status = SRC_EXT;
      default:                 src_status = SRC_NONE;
    endcase
  end

  // R4
  halt_until_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXT_WAIT && !osc_stable) |=> !cpu_run);

  // R7
  back_to_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_ext_q) |-> $past(state_q == ST_SUSP));

  // R3
  switch_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_ext_q) |-> (ext_osc_en && !cpu_run && !int_osc_en));

  // R12
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && wake && !suspend_req && !ext_set_pulse) |=> cpu_run);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl #(
  parameter int unsigned RESUME_SHORT = 128,
  parameter int unsigned RESUME_LONG  = 4000,
  parameter int unsigned WAKE_DELAY   = 8,
  parameter logic [7:0]  REG_ADDR     = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       osc_stable,
  input  logic       suspend_req,
  input  logic       wake,
  input  logic       tick,
  output logic       clk_sel_ext,
  output logic       int_osc_en,
  output logic       ext_osc_en,
  output logic       cpu_run,
  output logic [1:0] xtal_drive,
  output logic [1:0] src_status,
  output logic [2:0] wake_adj,
  output logic       lvr_dis,
  output logic       ptune_en
);
  import clksw_pkg::*;

  localparam int unsigned MAX_A = (RESUME_LONG > RESUME_SHORT) ? RESUME_LONG : RESUME_SHORT;
  localparam int unsigned MAX_L = (MAX_A > WAKE_DELAY) ? MAX_A : WAKE_DELAY;
  localparam int unsigned CW    = $clog2(MAX_L + 1);

  logic [7:0]    cfg_q;
  logic          ext_set_pulse;
  logic          dly_load, dly_busy, dly_expire;
  logic [CW-1:0] dly_len;
  logic          src_ext;

  clksw_cfg_reg #(.AW(8), .DW(8), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .cfg_q(cfg_q), .ext_set_pulse(ext_set_pulse)
  );

  clksw_seq #(
    .CW(CW), .RESUME_SHORT(RESUME_SHORT), .RESUME_LONG(RESUME_LONG),
    .WAKE_DELAY(WAKE_DELAY)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ext_set_pulse(ext_set_pulse),
    .ext_bit(cfg_q[BIT_EXT_REQ]), .long_sel(cfg_q[BIT_LONG]),
    .osc_stable(osc_stable), .suspend_req(suspend_req), .wake(wake),
    .dly_expire(dly_expire), .dly_load(dly_load), .dly_len(dly_len),
    .src_ext(src_ext), .cpu_run(cpu_run), .int_osc_en(int_osc_en),
    .ext_osc_en(ext_osc_en), .src_status(src_status)
  );

  clksw_delay #(.CW(CW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_len(dly_len),
    .tick(tick), .busy(dly_busy), .expire(dly_expire)
  );

  assign cfg_rdata   = cfg_q;
  assign clk_sel_ext = src_ext;
  assign wake_adj    = cfg_q[BIT_WADJ_LO +: 3];
  assign lvr_dis     = cfg_q[BIT_LVR_DIS];
  assign ptune_en    = cfg_q[BIT_PTUNE];

  always_comb begin
    if (src_ext)                 xtal_drive = XD_RELEASE;
    else if (cfg_q[BIT_OUT_DIS]) xtal_drive = XD_HIGH;
    else                         xtal_drive = XD_CLOCK;
  end

  // R8
  one_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_osc_en, ext_osc_en}));

  // R8
  run_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (int_osc_en || ext_osc_en));

  // R5
  delay_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_busy |-> !cpu_run);
endmodule

// File: tb/clksw_ctrl_test.sv
`timescale 1ns/1ps
module clksw_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_wr = 1'b0;
  logic [7:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       osc_stable = 1'b0;
  logic       suspend_req = 1'b0;
  logic       wake = 1'b0;
  logic       tick = 1'b1;
  logic       clk_sel_ext, int_osc_en, ext_osc_en, cpu_run;
  logic [1:0] xtal_drive, src_status;
  logic [2:0] wake_adj;
  logic       lvr_dis, ptune_en;
  logic       tick_toggle = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  clksw_ctrl uut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .cfg_rdata(cfg_rdata), .osc_stable(osc_stable),
    .suspend_req(suspend_req), .wake(wake), .tick(tick),
    .clk_sel_ext(clk_sel_ext), .int_osc_en(int_osc_en),
    .ext_osc_en(ext_osc_en), .cpu_run(cpu_run), .xtal_drive(xtal_drive),
    .src_status(src_status), .wake_adj(wake_adj), .lvr_dis(lvr_dis),
    .ptune_en(ptune_en)
  );

  always @(negedge clk) begin
    if (tick_toggle) tick <= ~tick;
    else             tick <= 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic pulse_susp();
    @(negedge clk);
    suspend_req = 1'b1;
    @(negedge clk);
    suspend_req = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
  endtask

  // counts negedges from the next posedge until cpu_run is seen high
  task automatic wait_run(output int n);
    n = 0;
    do begin
      @(negedge clk);
      wake = 1'b0;
      n++;
    end while (!cpu_run && n < 20000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick_toggle = 1'b0;
    osc_stable = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(cfg_rdata == 8'h00, "R1 reg", cfg_rdata, 0);
    chk(cpu_run && int_osc_en && !ext_osc_en && !clk_sel_ext, "R1 run/osc",
        {cpu_run, int_osc_en, ext_osc_en, clk_sel_ext}, 4'b1100);
    chk(xtal_drive == 2'd1, "R1 xtal", xtal_drive, 1);
    chk(src_status == 2'd0, "R1 status", src_status, 0);
  endtask

  task automatic t_regmap();
    wr(8'h12, 8'hFF);
    chk(cfg_rdata == 8'h00, "R2 foreign addr", cfg_rdata, 0);
    chk(cpu_run && !clk_sel_ext, "R2 no switch", cpu_run, 1);
    wr(8'hF8, 8'h7E);
    chk(cfg_rdata == 8'h7E, "R2 readback", cfg_rdata, 8'h7E);
    chk(wake_adj == 3'd7 && lvr_dis && ptune_en, "R2 fields",
        {wake_adj, lvr_dis, ptune_en}, 5'b11111);
    chk(xtal_drive == 2'd2, "R11 high", xtal_drive, 2);
    wr(8'hF8, 8'h00);
    chk(xtal_drive == 2'd1, "R11 clock", xtal_drive, 1);
  endtask

  task automatic t_switch_short();
    int n;
    osc_stable = 1'b0;
    wr(8'hF8, 8'h01);
    chk(!cpu_run && !int_osc_en && ext_osc_en && clk_sel_ext, "R3 halt",
        {cpu_run, int_osc_en, ext_osc_en, clk_sel_ext}, 4'b0011);
    chk(src_status == 2'd2, "R3 status", src_status, 2);
    repeat (40) @(negedge clk);
    chk(!cpu_run, "R4 still halted", cpu_run, 0);
    pulse_susp();
    chk(ext_osc_en && !cpu_run, "R12 suspend ignored", ext_osc_en, 1);
    osc_stable = 1'b1;
    wait_run(n);
    chk(n == 129, "R5 short delay", n, 129);
    chk(src_status == 2'd1, "R5 status", src_status, 1);
    chk(xtal_drive == 2'd0, "R11 release", xtal_drive, 0);
  endtask

  task automatic t_lock();
    wr(8'hF8, 8'h02);
    chk(clk_sel_ext && cpu_run && ext_osc_en && !int_osc_en, "R7 locked",
        {clk_sel_ext, cpu_run, ext_osc_en, int_osc_en}, 4'b1110);
    chk(xtal_drive == 2'd0, "R11 outdis ignored", xtal_drive, 0);
    pulse_wake();
    chk(cpu_run && clk_sel_ext, "R12 wake ignored", cpu_run, 1);
  endtask

  task automatic t_suspend_wake_int();
    int n;
    pulse_susp();
    chk(!cpu_run && !int_osc_en && !ext_osc_en, "R8 suspend",
        {cpu_run, int_osc_en, ext_osc_en}, 0);
    chk(src_status == 2'd2, "R8 status", src_status, 2);
    osc_stable = 1'b0;
    @(negedge clk);
    wake = 1'b1;
    wait_run(n);
    chk(n == 9, "R9 wake delay", n, 9);
    chk(!clk_sel_ext && int_osc_en && src_status == 2'd0, "R9 internal",
        clk_sel_ext, 0);
    chk(xtal_drive == 2'd2, "R11 high after wake", xtal_drive, 2);
  endtask

  task automatic t_wake_ext_long();
    int n;
    pulse_susp();
    wr(8'hF8, 8'h81);
    chk(cfg_rdata == 8'h81, "R2 write in suspend", cfg_rdata, 8'h81);
    chk(!cpu_run && !int_osc_en, "R8 held", cpu_run, 0);
    pulse_wake();
    chk(ext_osc_en && clk_sel_ext && !cpu_run, "R10 ext wake",
        {ext_osc_en, clk_sel_ext, cpu_run}, 3'b110);
    repeat (10) @(negedge clk);
    chk(!cpu_run, "R10 waits stable", cpu_run, 0);
    osc_stable = 1'b1;
    wait_run(n);
    chk(n == 4001, "R5 long delay", n, 4001);
  endtask

  task automatic t_tick_gate();
    int n;
    do_reset();
    wr(8'hF8, 8'h01);
    tick_toggle = 1'b1;
    osc_stable = 1'b1;
    wait_run(n);
    chk(n >= 250 && n <= 262, "R6 tick gating", n, 257);
    tick_toggle = 1'b0;
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_switch_short();
    t_lock();
    t_suspend_wake_int();
    t_wake_ext_long();
    t_tick_gate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule